// File: doc/BRIEF.md
# Transmit Data Chunk Framer

This block sits on the host side of a serial link to a combined MAC and PHY device. It takes Ethernet frame bytes from a byte stream that marks the first and last byte of each frame. It packs those bytes into fixed transmit chunks of one 32-bit header followed by 64 payload bytes. Each chunk goes out as seventeen 32-bit words, header first, toward an SPI word shifter.

The header tells the far end four things: whether the payload carries frame bytes, in which 32-bit word a frame starts, at which byte a frame ends, and whether a timestamp capture is wanted. It also carries an alternating sequence bit and an odd parity bit. A credit counter, loaded from the value the receive side reports, limits how many chunks with frame data may be issued. When no filled chunk may be sent, the block emits filler chunks whose payload the far end ignores, so the shifter always has words to send.

A frame that ends part way through a chunk may be followed in the same chunk by the next frame. That next frame starts at the next 32-bit word boundary, and its first byte must be offered in the cycle right after the last byte of the previous frame. Otherwise the chunk is closed and the next frame begins a fresh chunk.

Top module: `txc_framer`

## Requirements
- R1: Every header has bit 31 set to 1, bits 28..24, bit 15 and bits 5..1 at 0, and bit 29 equal to the `rx_suppress` input.
- R2: Bit 0 of every header makes the count of ones in the whole 32-bit header odd.
- R3: Bit 30 of the header is 0 in the first chunk after reset and inverts on every following chunk, filler or data.
- R4: A filler chunk (sent when no chunk is closed or credit is zero) has bit 21, bit 20, bit 14 and bits 7..6 at 0, carries 16 zero payload words and consumes no credit; a chunk with frame bytes has bit 21 at 1.
- R5: Payload byte k (0..63) travels in payload word k/4, in bits 31-8*(k%4) down to 24-8*(k%4); payload bytes that no frame byte filled are 0.
- R6: In the chunk where a frame begins, bit 20 is 1, bits 19..16 hold the payload word index of its first byte and bits 7..6 hold the `in_tsc` value given with that first byte (00 none, 01/10/11 capture slot A/B/C); in other chunks bit 20 and bits 7..6 are 0.
- R7: In the chunk where a frame ends, bit 14 is 1 and bits 13..8 hold the payload byte index of its last byte; in other chunks bit 14 is 0.
- R8: A chunk is closed once its 64th byte is written; the rest of the frame continues at byte 0 of the next chunk, which has bit 20 at 0.
- R9: After a frame that began in an earlier chunk ends before byte 63, a first byte offered in the very next cycle starts at the next 32-bit word boundary of the same chunk; if none is offered then, the chunk closes and the next frame starts at word 0 of a new chunk. A chunk in which a frame began closes when that frame ends.
- R10: The credit count is 0 after reset, takes `credit_value` on `credit_load`, and drops by one for each chunk with frame bytes sent; `in_ready` is low while the count is 0 or a closed chunk waits.
- R11: Bytes offered outside a frame without the first-byte marker are accepted and dropped, leaving no trace in any payload.
- R12: `out_valid` is high from the first cycle after reset; `out_first` marks header words; while `out_ready` is low a payload word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte offered |
| in_ready | output | 1 | Frame byte taken this cycle when high with `in_valid` |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_tsc | input | 2 | Timestamp capture request, sampled with the first byte |
| credit_load | input | 1 | Load the credit count |
| credit_value | input | CREDIT_W | Credit value reported by the receive side |
| rx_suppress | input | 1 | Copied to header bit 29 |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Shifter takes the output word |
| out_data | output | 32 | Header or payload word |
| out_first | output | 1 | Current output word is a header |

## Verification
The hardest case to reach is two frames sharing one chunk. It needs a frame that began in an earlier chunk to end mid-chunk, with the next first byte offered in exactly the following cycle, while credit is available and the chunk has not closed. The stimulus sends a 70-byte frame followed by an 80-byte frame with no idle cycle between them, so the second frame starts at word 2 of the second chunk and runs on into a third. A contrasting run inserts an idle cycle between the frames, and the chunk then closes with only the ending frame in it.

// File: rtl/txc_pkg.sv
package txc_pkg;

  localparam int PAY_BYTES = 64;
  localparam int WORD_BYTES = 4;
  localparam int PAY_WORDS = PAY_BYTES / WORD_BYTES;
  localparam int PTR_W = $clog2(PAY_BYTES) + 1;
  localparam int WIDX_W = $clog2(PAY_WORDS);
  localparam int BIDX_W = $clog2(PAY_BYTES);

  typedef struct packed {
    logic              dv;
    logic              sv;
    logic [WIDX_W-1:0] swo;
    logic              ev;
    logic [BIDX_W-1:0] ebo;
    logic [1:0]        tsc;
  } chunk_fields_t;

  typedef enum logic [1:0] {
    FILL_OUT  = 2'd0,
    FILL_BODY = 2'd1,
    FILL_GAP  = 2'd2
  } fill_state_e;

  // Odd parity over the upper 31 header bits: returns the bit that makes the total odd.
  function automatic logic odd_fill(input logic [30:0] upper);
    return ~(^upper);
  endfunction

  function automatic logic [31:0] build_header(input logic seq, input logic norx,
                                               input chunk_fields_t f);
    logic [31:0] h;
    h        = '0;
    h[31]    = 1'b1;
    h[30]    = seq;
    h[29]    = norx;
    h[21]    = f.dv;
    h[20]    = f.sv;
    h[19:16] = f.swo;
    h[14]    = f.ev;
    h[13:8]  = f.ebo;
    h[7:6]   = f.tsc;
    h[0]     = odd_fill(h[31:1]);
    return h;
  endfunction

  // Next 32-bit word boundary after the byte at position pos.
  function automatic logic [PTR_W-1:0] next_word_start(input logic [PTR_W-1:0] pos);
    logic [PTR_W-3:0] w;
    w = pos[PTR_W-1:2] + 1'b1;
    return {w, 2'b00};
  endfunction

endpackage

// File: rtl/txc_credit.sv
module txc_credit #(
  parameter int CREDIT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CREDIT_W-1:0] load_val,
  input  logic                consume,
  output logic [CREDIT_W-1:0] count,
  output logic                nonzero
);

  logic [CREDIT_W-1:0] base;

  assign base    = load ? load_val : count;
  assign nonzero = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (consume && base != '0) begin
      count <= base - 1'b1;
    end else begin
      count <= base;
    end
  end

  // R10: a data chunk is only issued while credit remains
  a_r10_consume_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> count != '0);

  // R10: each data chunk takes exactly one credit when no load coincides
  a_r10_consume_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/txc_assembler.sv
module txc_assembler
  import txc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [1:0]        in_tsc,
  input  logic              fill_ok,
  input  logic              release_chunk,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic              in_ready,
  output logic              sealed,
  output chunk_fields_t     fields,
  output logic [31:0]       rd_word
);

  fill_state_e       st;
  logic [PTR_W-1:0]  wr_ptr;
  logic [31:0]       pay_q [PAY_WORDS];

  // Named internal events
  logic              accept;
  logic              frame_start;
  logic              discard;
  logic              byte_wr;
  logic              frame_end;
  logic              chunk_full;
  logic              end_seal;
  logic              gap_seal;
  logic              seal_now;
  logic [PTR_W-1:0]  aligned_next;
  logic [4:0]        lane_shift;

  assign in_ready     = !sealed && fill_ok;
  assign accept       = in_valid && in_ready;
  assign frame_start  = accept && in_sof && (st != FILL_BODY);
  assign discard      = accept && !frame_start && (st != FILL_BODY);
  assign byte_wr      = frame_start || (accept && st == FILL_BODY);
  assign frame_end    = byte_wr && in_eof;
  assign aligned_next = next_word_start(wr_ptr);
  assign chunk_full   = byte_wr && !in_eof && (wr_ptr == PTR_W'(PAY_BYTES - 1));
  assign end_seal     = frame_end && (frame_start || fields.sv ||
                                      aligned_next == PTR_W'(PAY_BYTES));
  assign gap_seal     = (st == FILL_GAP) && !frame_start;
  assign seal_now     = chunk_full || end_seal || gap_seal;
  assign lane_shift   = {~wr_ptr[1:0], 3'b000};
  assign rd_word      = pay_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FILL_OUT;
      wr_ptr <= '0;
      sealed <= 1'b0;
      fields <= '0;
      for (int i = 0; i < PAY_WORDS; i++) pay_q[i] <= '0;
    end else if (release_chunk) begin
      wr_ptr <= '0;
      sealed <= 1'b0;
      fields <= '0;
      for (int i = 0; i < PAY_WORDS; i++) pay_q[i] <= '0;
    end else begin
      if (byte_wr) begin
        pay_q[wr_ptr[BIDX_W-1:2]][lane_shift +: 8] <= in_data;
        fields.dv <= 1'b1;
      end
      if (frame_start) begin
        fields.sv  <= 1'b1;
        fields.swo <= wr_ptr[BIDX_W-1:2];
        fields.tsc <= in_tsc;
      end
      if (frame_end) begin
        fields.ev  <= 1'b1;
        fields.ebo <= wr_ptr[BIDX_W-1:0];
      end
      if (seal_now) sealed <= 1'b1;
      if (frame_end)    wr_ptr <= aligned_next;
      else if (byte_wr) wr_ptr <= wr_ptr + 1'b1;
      if (frame_end)        st <= end_seal ? FILL_OUT : FILL_GAP;
      else if (frame_start) st <= FILL_BODY;
      else if (gap_seal)    st <= FILL_OUT;
    end
  end

  // R8: writing the last payload byte closes the chunk
  a_r8_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !release_chunk && wr_ptr == PTR_W'(PAY_BYTES - 1)) |=> sealed);

  // R6: a frame always begins on a 32-bit word boundary
  a_r6_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> wr_ptr[1:0] == 2'b00);

  // R9: a chunk never takes a second frame end (frames after an end must be long)
  a_r9_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !fields.ev);

  // R11: dropped bytes leave the write position untouched
  a_r11_drop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !release_chunk) |=> $stable(wr_ptr));

  // R10: a closed chunk stays closed until it has been sent
  a_r10_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && !release_chunk) |=> sealed);

endmodule

// File: rtl/txc_sender.sv
module txc_sender
  import txc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_ready,
  input  logic              chunk_ready,
  input  logic              credit_ok,
  input  chunk_fields_t     fields,
  input  logic              norx,
  input  logic [31:0]       rd_word,
  output logic              out_valid,
  output logic              out_first,
  output logic [31:0]       out_data,
  output logic [WIDX_W-1:0] rd_idx,
  output logic              release_chunk,
  output logic              consume
);

  localparam int BEAT_W = $clog2(PAY_WORDS + 1);

  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] beat_m1;
  logic              is_data;
  logic              seq;
  logic              run_q;
  logic              fire;
  logic              take_data;
  logic              last_beat;
  logic [31:0]       hdr;

  assign out_valid     = run_q;
  assign fire          = run_q && out_ready;
  assign out_first     = (beat == '0);
  assign take_data     = chunk_ready && credit_ok;
  assign hdr           = build_header(seq, norx, take_data ? fields : '0);
  assign beat_m1       = beat - 1'b1;
  assign rd_idx        = beat_m1[WIDX_W-1:0];
  assign last_beat     = (beat == BEAT_W'(PAY_WORDS));
  assign out_data      = out_first ? hdr : (is_data ? rd_word : '0);
  assign consume       = fire && out_first && take_data;
  assign release_chunk = fire && last_beat && is_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      beat    <= '0;
      is_data <= 1'b0;
      seq     <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (fire) begin
        if (out_first) begin
          is_data <= take_data;
          seq     <= ~seq;
          beat    <= BEAT_W'(1);
        end else if (last_beat) begin
          beat <= '0;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  // R2: every header leaves with an odd count of ones
  a_r2_odd_header: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> $countones(out_data) % 2 == 1);

  // R12: a payload word waiting on the shifter does not change
  a_r12_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_first) |=> $stable(out_data));

  // R3: the sequence bit in consecutive headers differs
  a_r3_seq_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_first) |=> seq != $past(seq));

  // R4: filler payload words are zero
  a_r4_filler_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first && !is_data) |-> out_data == '0);

endmodule

// File: rtl/txc_framer.sv
module txc_framer
  import txc_pkg::*;
#(
  parameter int CREDIT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic [1:0]          in_tsc,
  input  logic                credit_load,
  input  logic [CREDIT_W-1:0] credit_value,
  input  logic                rx_suppress,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_data,
  output logic                out_first
);

  logic              sealed;
  logic              credit_ok;
  logic              release_chunk;
  logic              consume;
  logic [WIDX_W-1:0] rd_idx;
  logic [31:0]       rd_word;
  logic [CREDIT_W-1:0] credit_count;
  chunk_fields_t     fields;

  txc_credit #(.CREDIT_W(CREDIT_W)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (credit_load),
    .load_val (credit_value),
    .consume  (consume),
    .count    (credit_count),
    .nonzero  (credit_ok)
  );

  txc_assembler u_asm (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_tsc        (in_tsc),
    .fill_ok       (credit_ok),
    .release_chunk (release_chunk),
    .rd_idx        (rd_idx),
    .in_ready      (in_ready),
    .sealed        (sealed),
    .fields        (fields),
    .rd_word       (rd_word)
  );

  txc_sender u_send (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_ready     (out_ready),
    .chunk_ready   (sealed),
    .credit_ok     (credit_ok),
    .fields        (fields),
    .norx          (rx_suppress),
    .rd_word       (rd_word),
    .out_valid     (out_valid),
    .out_first     (out_first),
    .out_data      (out_data),
    .rd_idx        (rd_idx),
    .release_chunk (release_chunk),
    .consume       (consume)
  );

  // R10: no frame byte is taken while credit is exhausted
  a_r10_stall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_count == '0) |-> !in_ready);

  // R4: a header announcing frame data only leaves with credit in hand
  a_r4_data_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_first && out_data[21]) |-> credit_count != '0);

endmodule

// File: tb/tb_txc_framer.sv
module tb_txc_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic [1:0] in_tsc = '0;
  logic       credit_load = 1'b0;
  logic [4:0] credit_value = '0;
  logic       rx_suppress = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [31:0] out_data;
  logic       out_first;

  always #5 clk = ~clk;

  txc_framer #(.CREDIT_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_tsc(in_tsc),
    .credit_load(credit_load), .credit_value(credit_value),
    .rx_suppress(rx_suppress), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: collects chunks and checks every header
  int          beat_b = 0;
  int          dcnt = 0;
  int          prev_seq = -1;
  bit          seen_first = 1'b0;
  logic [31:0] first_hdr = '0;
  logic [31:0] last_hdr = '0;
  logic [31:0] cur_hdr;
  logic [31:0] cur_pay [16];
  logic [31:0] lh [64];
  logic [31:0] lp [64][16];

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      chk(out_first == (beat_b == 0), "R12 first marker", {31'd0, out_first},
          {31'd0, beat_b == 0});
      if (beat_b == 0) begin
        cur_hdr  = out_data;
        last_hdr = out_data;
        if (!seen_first) begin
          seen_first = 1'b1;
          first_hdr  = out_data;
        end
        chk(cur_hdr[31] && cur_hdr[28:24] == 0 && !cur_hdr[15] && cur_hdr[5:1] == 0
            && cur_hdr[29] == rx_suppress, "R1 fixed header bits", cur_hdr,
            {1'b1, cur_hdr[30], rx_suppress, 29'd0} | (cur_hdr & 32'h003F_40C1));
        chk($countones(cur_hdr) % 2 == 1, "R2 odd parity", cur_hdr, cur_hdr ^ 32'h1);
        if (prev_seq >= 0)
          chk(cur_hdr[30] != prev_seq[0], "R3 sequence alternates",
              {31'd0, cur_hdr[30]}, {31'd0, ~prev_seq[0]});
        prev_seq = int'(cur_hdr[30]);
        beat_b = 1;
      end else begin
        cur_pay[beat_b-1] = out_data;
        if (beat_b == 16) begin
          if (cur_hdr[21]) begin
            if (dcnt < 64) begin
              lh[dcnt] = cur_hdr;
              for (int i = 0; i < 16; i++) lp[dcnt][i] = cur_pay[i];
            end
            dcnt++;
          end else begin
            bit z = 1'b1;
            for (int i = 0; i < 16; i++) if (cur_pay[i] != 0) z = 1'b0;
            chk(z && !cur_hdr[20] && !cur_hdr[14] && cur_hdr[7:6] == 0,
                "R4 filler chunk empty", cur_hdr, cur_hdr & 32'hFFAF_BF3F);
          end
          beat_b = 0;
        end else begin
          beat_b++;
        end
      end
    end
  end

  function automatic logic [31:0] mk(input bit dv, input bit sv, input int swo,
                                     input bit ev, input int ebo, input int tsc,
                                     input bit norx);
    logic [31:0] h;
    h = 32'h8000_0000;
    h = h | (32'(norx) << 29) | (32'(dv) << 21) | (32'(sv) << 20);
    h = h | ((32'(swo) & 32'hF) << 16) | (32'(ev) << 14);
    h = h | ((32'(ebo) & 32'h3F) << 8) | ((32'(tsc) & 32'h3) << 6);
    return h;
  endfunction

  task automatic chk_hdr(input int ci, input logic [31:0] exp, input string req);
    chk((lh[ci] & 32'hBFFF_FFFE) == exp, req, lh[ci] & 32'hBFFF_FFFE, exp);
  endtask

  function automatic logic [7:0] gb(input int ci, input int b);
    logic [31:0] w;
    w = lp[ci][b / 4];
    return w[(3 - (b % 4)) * 8 +: 8];
  endfunction

  task automatic chk_bytes(input int ci, input int pos, input logic [7:0] v0,
                           input int n, input string req);
    bit ok = 1'b1;
    logic [7:0] a = '0;
    logic [7:0] e = '0;
    for (int k = 0; k < n; k++) begin
      if (ok && gb(ci, pos + k) != 8'(v0 + k)) begin
        ok = 1'b0;
        a  = gb(ci, pos + k);
        e  = 8'(v0 + k);
      end
    end
    chk(ok, req, {24'd0, a}, {24'd0, e});
  endtask

  task automatic chk_zero(input int ci, input int from, input int upto, input string req);
    bit ok = 1'b1;
    logic [7:0] a = '0;
    for (int b = from; b <= upto; b++)
      if (ok && gb(ci, b) != 8'h00) begin
        ok = 1'b0;
        a  = gb(ci, b);
      end
    chk(ok, req, {24'd0, a}, 32'd0);
  endtask

  task automatic drive_byte(input logic [7:0] d, input logic s, input logic e,
                            input logic [1:0] t);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_tsc = t;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] v0, input logic [1:0] t);
    for (int k = 0; k < len; k++)
      drive_byte(8'(v0 + k), k == 0, k == len - 1, t);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic load_credit(input logic [4:0] v);
    @(negedge clk);
    credit_load = 1'b1; credit_value = v;
    @(negedge clk);
    credit_load = 1'b0;
  endtask

  task automatic wait_chunks(input int target, input string req);
    int n = 0;
    while (dcnt < target && n < 3000) begin
      @(posedge clk);
      n++;
    end
    chk(dcnt >= target, req, 32'(dcnt), 32'(target));
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R12 valid after reset", {31'd0, out_valid}, 32'd1);
    chk(in_ready == 1'b0, "R10 zero credit at reset", {31'd0, in_ready}, 32'd0);
    chk(first_hdr == 32'h8000_0000, "R3 R4 first header is even filler", first_hdr,
        32'h8000_0000);
  endtask

  task automatic t_short();
    int b = dcnt;
    load_credit(5'd16);
    send_frame(10, 8'h10, 2'b01);
    idle_in();
    wait_chunks(b + 1, "R6 short frame chunk sent");
    chk_hdr(b, mk(1, 1, 0, 1, 9, 1, 0), "R6 R7 short frame header");
    chk_bytes(b, 0, 8'h10, 10, "R5 short frame bytes");
    chk_zero(b, 10, 63, "R5 short frame padding");
  endtask

  task automatic t_span();
    int b = dcnt;
    send_frame(100, 8'h40, 2'b00);
    idle_in();
    wait_chunks(b + 2, "R8 spanning frame chunks");
    chk_hdr(b, mk(1, 1, 0, 0, 0, 0, 0), "R8 first part header");
    chk_bytes(b, 0, 8'h40, 64, "R8 first part bytes");
    chk_hdr(b + 1, mk(1, 0, 0, 1, 35, 0, 0), "R7 R8 tail header");
    chk_bytes(b + 1, 0, 8'h80, 36, "R8 tail bytes");
    chk_zero(b + 1, 36, 63, "R5 tail padding");
  endtask

  task automatic t_back_to_back();
    int b = dcnt;
    send_frame(70, 8'h00, 2'b00);
    send_frame(80, 8'h80, 2'b10);
    idle_in();
    wait_chunks(b + 3, "R9 back to back chunks");
    chk_hdr(b, mk(1, 1, 0, 0, 0, 0, 0), "R9 chunk one header");
    chk_hdr(b + 1, mk(1, 1, 2, 1, 5, 2, 0), "R9 shared chunk header");
    chk_bytes(b + 1, 0, 8'h40, 6, "R9 shared chunk ending bytes");
    chk_zero(b + 1, 6, 7, "R9 alignment padding");
    chk_bytes(b + 1, 8, 8'h80, 56, "R9 shared chunk starting bytes");
    chk_hdr(b + 2, mk(1, 0, 0, 1, 23, 0, 0), "R9 third chunk header");
    chk_bytes(b + 2, 0, 8'hB8, 24, "R9 third chunk bytes");
  endtask

  task automatic t_gap();
    int b = dcnt;
    send_frame(66, 8'h20, 2'b00);
    idle_in();
    idle_in();
    send_frame(10, 8'hC0, 2'b00);
    idle_in();
    wait_chunks(b + 3, "R9 gap chunks");
    chk_hdr(b + 1, mk(1, 0, 0, 1, 1, 0, 0), "R9 gap closes chunk");
    chk_zero(b + 1, 2, 63, "R9 gap chunk padding");
    chk_hdr(b + 2, mk(1, 1, 0, 1, 9, 0, 0), "R9 next frame in new chunk");
    chk_bytes(b + 2, 0, 8'hC0, 10, "R9 next frame bytes");
  endtask

  task automatic t_discard();
    int b = dcnt;
    drive_byte(8'hEE, 1'b0, 1'b0, 2'b00);
    drive_byte(8'hEF, 1'b0, 1'b0, 2'b00);
    drive_byte(8'hF0, 1'b0, 1'b1, 2'b00);
    idle_in();
    send_frame(8, 8'h51, 2'b11);
    idle_in();
    wait_chunks(b + 1, "R11 frame after stray bytes");
    chk(dcnt == b + 1, "R11 stray bytes make no chunk", 32'(dcnt), 32'(b + 1));
    chk_hdr(b, mk(1, 1, 0, 1, 7, 3, 0), "R11 R6 header after stray bytes");
    chk_bytes(b, 0, 8'h51, 8, "R11 payload holds only frame bytes");
  endtask

  task automatic t_norx();
    @(negedge clk);
    rx_suppress = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk(last_hdr[29] == 1'b1, "R1 receive suppress bit", last_hdr, last_hdr | 32'h2000_0000);
    @(negedge clk);
    rx_suppress = 1'b0;
    repeat (40) @(negedge clk);
    #1;
    chk(last_hdr[29] == 1'b0, "R1 receive suppress cleared", last_hdr, last_hdr & 32'hDFFF_FFFF);
  endtask

  task automatic t_credit();
    int b = dcnt;
    bit stalled = 1'b1;
    load_credit(5'd1);
    send_frame(10, 8'h33, 2'b00);
    idle_in();
    wait_chunks(b + 1, "R10 single credit chunk");
    repeat (40) begin
      @(negedge clk);
      #1;
      if (in_ready) stalled = 1'b0;
    end
    chk(stalled, "R10 ready low at zero credit", {31'd0, !stalled}, 32'd0);
    chk(dcnt == b + 1, "R10 no data chunk without credit", 32'(dcnt), 32'(b + 1));
    load_credit(5'd2);
    send_frame(12, 8'h61, 2'b00);
    idle_in();
    wait_chunks(b + 2, "R10 reload resumes");
    chk_hdr(b + 1, mk(1, 1, 0, 1, 11, 0, 0), "R10 header after reload");
  endtask

  task automatic t_backpressure();
    int b = dcnt;
    load_credit(5'd4);
    fork
      begin
        send_frame(30, 8'h90, 2'b11);
        idle_in();
      end
      begin
        for (int i = 0; i < 150; i++) begin
          @(negedge clk);
          out_ready = (i % 3) != 0;
        end
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    wait_chunks(b + 1, "R12 chunk under backpressure");
    chk_hdr(b, mk(1, 1, 0, 1, 29, 3, 0), "R12 header under backpressure");
    chk_bytes(b, 0, 8'h90, 30, "R12 payload under backpressure");
    chk_zero(b, 30, 63, "R5 padding under backpressure");
  endtask

  initial begin
    t_reset();
    t_short();
    t_span();
    t_back_to_back();
    t_gap();
    t_discard();
    t_norx();
    t_backpressure();
    t_credit();
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule